// File: doc/BRIEF.md
# Paged Address Translator with Lookaside Buffer

This block turns a virtual byte address into a physical byte address for a paged memory system. The virtual address is cut into a high page-number field and a low in-page offset. The page number becomes a frame number, and the offset passes through unchanged. Each request first searches a small, fully associative lookaside buffer. The buffer holds recent page-to-frame pairs and compares all of its tags in one step.

When the buffer misses, the block spends one extra cycle reading a page table held in a local register array. A valid entry produces the physical address and is copied into the buffer. An invalid entry raises a fault flag and produces no address. Software owns the table through a separate write port. It resolves a fault by writing a valid entry for that page. Each table write removes any buffered copy of the same page, and a flush input empties the whole buffer.

The default build uses a 3-bit page number, a 2-bit frame number, a 10-bit offset and four buffer slots. A second intended build uses a 5-bit page number, a 4-bit frame number and eight slots.

Top module: `xlate_top`

## Requirements
- R1: For a valid translation, `rsp_paddr` is the frame number in its high bits with the 10-bit request offset unchanged in its low bits.
- R2: With table entry 5 valid and holding frame 2'b01, virtual address 13'b1010101010011 translates to physical address 12'b010101010011.
- R3: A request accepted while its page is held in the buffer is answered with `rsp_valid` one cycle after acceptance, with `rsp_fault` low.
- R4: A request that misses the buffer is answered two cycles after acceptance, and `req_ready` is low during the table-read cycle.
- R5: A miss whose table entry has its valid bit at 0 returns `rsp_fault`=1 and `rsp_paddr`=0, and nothing is installed in the buffer, so a repeat request also takes two cycles.
- R6: A miss whose table entry is valid installs the page-to-frame pair in the buffer, so the next request to that page hits.
- R7: A refill uses the lowest-numbered empty slot first. When all slots are full, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances after each such replacement.
- R8: A table write through `pt_we` removes any buffered copy of the page number `pt_idx`, so the next request to that page re-reads the table and sees the new entry. Other buffered pages are unaffected.
- R9: A one-cycle `flush` pulse empties every buffer slot, so the next request to any page takes the two-cycle path.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `rsp_fault`=0, and every table and buffer entry is invalid, so the first access to any page faults.
- R11: At most one buffer slot matches any page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VPN_W+OFF_W | Virtual byte address |
| rsp_valid | output | 1 | One-cycle pulse that marks a result |
| rsp_paddr | output | PFN_W+OFF_W | Physical byte address, 0 on fault |
| rsp_fault | output | 1 | Page fault: table entry invalid |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | VPN_W | Page number of the entry to write |
| pt_valid | input | 1 | Valid bit to store |
| pt_pfn | input | PFN_W | Frame number to store |
| flush | input | 1 | Empty the lookaside buffer |

## Verification
The bench measures the response latency of every request. A design that refilled the buffer on a fault, or never refilled it, would show the wrong one- or two-cycle timing on the repeat access. Round-robin replacement is checked by filling all four slots and then requesting a fifth page. Which older page now misses shows the victim, so a design that evicted the wrong slot, or kept the pointer still, would be caught. Stale mappings are checked by rewriting an entry that is already buffered, by flushing, and by resetting in the middle of a run. A design that kept an old copy in any of these cases would return the previous frame instead of refetching or faulting.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xl_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xlate_ptable.sv
module xlate_ptable #(
    parameter int VPN_W = 3,
    parameter int PFN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [VPN_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PFN_W-1:0] rd_pfn
);
    localparam int DEPTH = 1 << VPN_W;

    logic [DEPTH-1:0] vld_q;
    logic [PFN_W-1:0] pfn_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_pfn   = pfn_q[rd_idx];

endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     slot_valid,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] pick,
    output logic             all_full
);
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = rr_ptr;
        for (int i = 0; i < N; i++) begin
            if (!slot_valid[i] && !found) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign all_full = &slot_valid;

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int VPN_W = 3,
    parameter int PFN_W = 2,
    parameter int N     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush
);
    localparam int IDX_W = idx_width(N);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N-1:0]     valid_q;
    logic [VPN_W-1:0] tag_q [N];
    logic [PFN_W-1:0] pfn_q [N];
    logic [IDX_W-1:0] rr_q;
    logic [N-1:0]     hit_vec;
    logic [N-1:0]     inv_vec;
    logic [IDX_W-1:0] victim;
    logic             full;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
        assign inv_vec[g] = valid_q[g] && (tag_q[g] == inv_vpn);
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N; i++) begin
            lk_pfn = lk_pfn | (hit_vec[i] ? pfn_q[i] : '0);
        end
    end
    assign lk_hit = |hit_vec;

    xlate_victim #(.N(N), .IDX_W(IDX_W)) victim_i (
        .slot_valid (valid_q),
        .rr_ptr     (rr_q),
        .pick       (victim),
        .all_full   (full)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[victim] <= 1'b1;
            end
            for (int i = 0; i < N; i++) begin
                if (inv_en && inv_vec[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[victim] <= fill_vpn;
            pfn_q[victim] <= fill_pfn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill_en && full && !flush) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    AST_TLB_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R11

    AST_TLB_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0)); // R9

endmodule

// File: rtl/xlate_top.sv
module xlate_top
    import xlate_pkg::*;
#(
    parameter int VPN_W = 3,
    parameter int PFN_W = 2,
    parameter int OFF_W = 10,
    parameter int TLB_N = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    output logic                   rsp_valid,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic                   rsp_fault,
    input  logic                   pt_we,
    input  logic [VPN_W-1:0]       pt_idx,
    input  logic                   pt_valid,
    input  logic [PFN_W-1:0]       pt_pfn,
    input  logic                   flush
);
    localparam int VA_W = VPN_W + OFF_W;

    xl_state_e         state_q;
    logic [VA_W-1:0]   vaddr_q;
    logic              accept;
    logic [VPN_W-1:0]  req_vpn;
    logic [OFF_W-1:0]  req_off;
    logic [VPN_W-1:0]  walk_vpn;
    logic [OFF_W-1:0]  walk_off;
    logic              tlb_hit;
    logic [PFN_W-1:0]  tlb_pfn;
    logic              pte_valid;
    logic [PFN_W-1:0]  pte_pfn;
    logic              fill_en;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign walk_vpn  = vaddr_q[VA_W-1:OFF_W];
    assign walk_off  = vaddr_q[OFF_W-1:0];

    // a write or flush in the refill cycle wins over the refill
    assign fill_en = (state_q == ST_WALK) && pte_valid && !flush
                     && !(pt_we && (pt_idx == walk_vpn));

    xlate_ptable #(.VPN_W(VPN_W), .PFN_W(PFN_W)) ptable_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (pt_we),
        .wr_idx   (pt_idx),
        .wr_valid (pt_valid),
        .wr_pfn   (pt_pfn),
        .rd_idx   (walk_vpn),
        .rd_valid (pte_valid),
        .rd_pfn   (pte_pfn)
    );

    xlate_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .N(TLB_N)) tlb_i (
        .clk      (clk),
        .rst      (rst),
        .lk_vpn   (req_vpn),
        .lk_hit   (tlb_hit),
        .lk_pfn   (tlb_pfn),
        .fill_en  (fill_en),
        .fill_vpn (walk_vpn),
        .fill_pfn (pte_pfn),
        .inv_en   (pt_we),
        .inv_vpn  (pt_idx),
        .flush    (flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            vaddr_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        vaddr_q <= req_vaddr;
                        if (tlb_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_paddr <= {tlb_pfn, req_off};
                        end else begin
                            state_q <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    state_q   <= ST_IDLE;
                    rsp_valid <= 1'b1;
                    if (pte_valid) begin
                        rsp_paddr <= {pte_pfn, walk_off};
                    end else begin
                        rsp_paddr <= '0;
                        rsp_fault <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (accept && tlb_hit) |=> (rsp_valid && !rsp_fault)); // R3

    AST_WALK_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WALK) |=> (rsp_valid && req_ready)); // R4

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
        (accept && !tlb_hit) |=> (!req_ready && !rsp_valid)); // R4

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0)); // R5

endmodule

// File: tb/xlate_top_tb_top.sv
module xlate_top_tb_top;
    localparam int VPN_W = 3;
    localparam int PFN_W = 2;
    localparam int OFF_W = 10;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic [1:0]      lat;
        logic            flt;
        logic [PA_W-1:0] pa;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{13'b101_0101010011, 2'd2, 1'b0, 12'b01_0101010011}, // R2 first touch
        '{13'b101_0101010011, 2'd1, 1'b0, 12'b01_0101010011}, // R6 refilled -> hit
        '{13'b010_1111111111, 2'd2, 1'b0, 12'b11_1111111111}, // R1 top offset
        '{13'b010_0000000000, 2'd1, 1'b0, 12'b11_0000000000}, // R1 zero offset
        '{13'b110_0000000001, 2'd2, 1'b1, 12'b00_0000000000}, // R5 fault
        '{13'b110_0000000001, 2'd2, 1'b1, 12'b00_0000000000}, // R5 not installed
        '{13'b000_0101010101, 2'd2, 1'b0, 12'b10_0101010101}, // R1 page 0
        '{13'b101_0000000000, 2'd1, 1'b0, 12'b01_0000000000}  // R3 still buffered
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic            rsp_fault;
    logic            pt_we = 1'b0;
    logic [VPN_W-1:0] pt_idx = '0;
    logic            pt_valid = 1'b0;
    logic [PFN_W-1:0] pt_pfn = '0;
    logic            flush = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xlate_top #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .TLB_N(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vaddr (req_vaddr),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault),
        .pt_we     (pt_we),
        .pt_idx    (pt_idx),
        .pt_valid  (pt_valid),
        .pt_pfn    (pt_pfn),
        .flush     (flush)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pt_write(input int idx, input bit v, input int pfn);
        @(negedge clk);
        pt_we    = 1'b1;
        pt_idx   = VPN_W'(idx);
        pt_valid = v;
        pt_pfn   = PFN_W'(pfn);
        @(negedge clk);
        pt_we    = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic do_req(input logic [VA_W-1:0] va, output int lat,
                          output logic [PA_W-1:0] pa, output logic flt,
                          output logic rdy1);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        rdy1 = req_ready;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        pa  = rsp_paddr;
        flt = rsp_fault;
    endtask

    task automatic req_lat(input logic [VA_W-1:0] va, input int exp_lat, input string req);
        int lat;
        logic [PA_W-1:0] pa;
        logic flt, rdy1;
        do_req(va, lat, pa, flt, rdy1);
        chk(lat == exp_lat, req, lat, exp_lat);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [PA_W-1:0] pa;
        logic flt, rdy1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
        chk(rsp_fault == 1'b0, "R10 rsp_fault", int'(rsp_fault), 0);
        do_req(13'b101_0101010011, lat, pa, flt, rdy1);
        chk(flt == 1'b1, "R10 empty table faults", int'(flt), 1);

        pt_write(5, 1'b1, 1);
        pt_write(2, 1'b1, 3);
        pt_write(0, 1'b1, 2);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].va, lat, pa, flt, rdy1);
            chk(lat == int'(VECS[i].lat), $sformatf("R3/R4 vec%0d latency", i), lat, int'(VECS[i].lat));
            chk(flt == VECS[i].flt, $sformatf("R5 vec%0d fault", i), int'(flt), int'(VECS[i].flt));
            chk(pa == VECS[i].pa, $sformatf("R1/R2 vec%0d paddr", i), int'(pa), int'(VECS[i].pa));
            if (VECS[i].lat == 2'd2)
                chk(rdy1 == 1'b0, $sformatf("R4 vec%0d ready low in walk", i), int'(rdy1), 0);
        end

        // R8: rewrite a buffered entry
        pt_write(5, 1'b1, 2);
        do_req(13'b101_0101010011, lat, pa, flt, rdy1);
        chk(lat == 2, "R8 rewritten page misses", lat, 2);
        chk(pa == 12'b10_0101010011, "R8 new frame", int'(pa), int'(12'b10_0101010011));
        req_lat(13'b010_0000000001, 1, "R8 other page still hits");

        // R9: flush
        do_flush();
        req_lat(13'b010_0000000001, 2, "R9 flushed page misses");

        // R7: replacement order
        do_flush();
        pt_write(1, 1'b1, 0);
        pt_write(3, 1'b1, 1);
        pt_write(4, 1'b1, 3);
        req_lat(13'b000_0000000000, 2, "R7 fill slot0");
        req_lat(13'b001_0000000000, 2, "R7 fill slot1");
        req_lat(13'b010_0000000000, 2, "R7 fill slot2");
        req_lat(13'b011_0000000000, 2, "R7 fill slot3");
        req_lat(13'b100_0000000000, 2, "R7 replace slot0");
        req_lat(13'b001_0000000000, 1, "R7 slot1 kept");
        req_lat(13'b000_0000000000, 2, "R7 page0 evicted");
        req_lat(13'b001_0000000000, 2, "R7 pointer advanced to slot1");
        req_lat(13'b100_0000000000, 1, "R7 page4 kept");

        // R10: reset mid-run clears table and buffer
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_req(13'b100_0000000000, lat, pa, flt, rdy1);
        chk(flt == 1'b1, "R10 fault after reset", int'(flt), 1);
        chk(lat == 2, "R10 miss after reset", lat, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule